// File: doc/BRIEF.md
# Floppy Controller Data-Rate and Power Control Register

This block holds the host-programmable timing controls of a floppy disk controller. A host on a simple byte-wide bus (address, write strobe, read strobe, data) programs a write-only rate/power select register. A second configuration control register can also set the data rate. The block drives several outputs for the rest of the controller:

- the 2-bit data-rate code in effect;
- the 3-bit write-precompensation code;
- a manual low-power flag that gates the controller clock and data separator;
- a single-cycle software-reset pulse.

The effective rate belongs to whichever of the two registers the host wrote last. The reset bit of the select register clears itself. Low-power mode ends on its own when the host touches the data register or the main status register. The select register itself cannot be read back. Instead, every write to it is mirrored into a shadow copy that the host can read at a separate offset. The data path, the data separator and the command sequencer are outside this block; only their bus accesses reach it.

Top module: `fdc_rate_ctrl`

## Requirements
- R1: After hardware reset the rate code is 2'b10 (250 Kbps), the precompensation code is 3'b000, low power is 0, the reset pulse is 0, and the shadow register reads 8'h02.
- R2: A write to offset 4 loads the rate code from data bits 1:0, the precompensation code from bits 4:2 and low power from bit 6. The shadow register then reads back the written byte with bit 7 forced to 0. All of these are visible from the clock edge that samples the write.
- R3: A write to offset 7 changes only the rate code, taken from data bits 1:0. The precompensation code, low power and the shadow register keep their values.
- R4: The rate code always equals the rate field of the most recent write to offset 4 or offset 7, whichever came last.
- R5: A write to offset 4 with bit 7 set drives the reset pulse high for exactly the one cycle after the write edge. It forces low power to 0, and the other fields still load from that write.
- R6: While low power is 1, a read at offset 4 or a read or write at offset 5 clears it at that access's clock edge.
- R7: A read at offset 4 never returns the select register: read data is 0 at every offset except the shadow offset 6. Reads change no output apart from the low-power exit of R6.
- R8: Rate codes are output as 00 = 500 Kbps, 01 = 300 Kbps, 10 = 250 Kbps and 11 = 1 Mbps, unchanged from the written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| busAddr | input | 3 | Register offset within the controller block |
| busWr | input | 1 | Write strobe, one access per high cycle |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (shadow at offset 6, else 0) |
| rateCode | output | 2 | Active data-rate code |
| precompCode | output | 3 | Write-precompensation code |
| lowPower | output | 1 | Manual low-power flag |
| swResetPulse | output | 1 | One-cycle software-reset pulse |

## Verification
A wrong rate-ownership state shows up on `rateCode` at the first sampled cycle after a write to the other register. A stuck or lost low-power state shows up on `lowPower` one edge after a data or status access. A mis-captured byte shows up on the next shadow read. A reset bit that fails to clear itself would be seen as a reset pulse longer than one cycle. All of these are visible at the ports within one clock of the offending access, and the bench compares every output after every access.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam logic [ADDR_W-1:0] OFS_SEL    = 3'd4; // select write / status read
  localparam logic [ADDR_W-1:0] OFS_DATA   = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_SHADOW = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_CCR    = 3'd7;
  localparam logic [DATA_W-1:0] SEL_RESET  = 8'h02;

  typedef struct packed {
    logic selWr;
    logic ccrWr;
    logic lpExit;
    logic shadowRd;
  } strobes_t;
endpackage

// File: rtl/fdc_rate_decode.sv
module fdc_rate_decode
  import fdc_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobes_t          strobes
);
  logic hitSel, hitData, hitShadow, hitCcr;

  always_comb begin
    hitSel    = (busAddr == OFS_SEL);
    hitData   = (busAddr == OFS_DATA);
    hitShadow = (busAddr == OFS_SHADOW);
    hitCcr    = (busAddr == OFS_CCR);
    strobes.selWr    = busWr && hitSel;
    strobes.ccrWr    = busWr && hitCcr;
    strobes.lpExit   = (busRd && hitSel) || ((busRd || busWr) && hitData);
    strobes.shadowRd = busRd && hitShadow;
  end

  // R7: select register has no read path; only the shadow strobe reads
  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selWr, strobes.ccrWr, strobes.shadowRd}));
endmodule

// File: rtl/fdc_rate_regs.sv
module fdc_rate_regs
  import fdc_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [1:0]        rateCode,
  output logic [2:0]        precompCode,
  output logic              lowPower,
  output logic              swResetPulse
);
  logic [DATA_W-1:0] shadowReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateCode     <= SEL_RESET[1:0];
      precompCode  <= SEL_RESET[4:2];
      lowPower     <= 1'b0;
      swResetPulse <= 1'b0;
      shadowReg    <= SEL_RESET;
    end else begin
      swResetPulse <= strobes.selWr && busWdata[7];
      if (strobes.selWr) begin
        rateCode    <= busWdata[1:0];
        precompCode <= busWdata[4:2];
        lowPower    <= busWdata[6] && !busWdata[7];
        shadowReg   <= {1'b0, busWdata[6:0]};
      end else begin
        if (strobes.ccrWr) rateCode <= busWdata[1:0];
        if (strobes.lpExit) lowPower <= 1'b0;
      end
    end
  end

  always_comb busRdata = strobes.shadowRd ? shadowReg : '0;

  assert_ccr_rate_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ccrWr |=> $stable(precompCode) && $stable(lowPower) && $stable(shadowReg));
  assert_pulse_after_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    swResetPulse |-> !lowPower);
  assert_lp_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lpExit && !strobes.selWr) |=> !lowPower);
  assert_shadow_top_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shadowRd |-> !busRdata[7]);
endmodule

// File: rtl/fdc_rate_ctrl.sv
module fdc_rate_ctrl
  import fdc_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [1:0]        rateCode,
  output logic [2:0]        precompCode,
  output logic              lowPower,
  output logic              swResetPulse
);
  strobes_t strobes;

  fdc_rate_decode u_decode (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .strobes(strobes)
  );

  fdc_rate_regs u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .busRdata(busRdata), .rateCode(rateCode), .precompCode(precompCode),
    .lowPower(lowPower), .swResetPulse(swResetPulse)
  );
endmodule

// File: tb/fdc_rate_ctrl_bench.sv
module fdc_rate_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [1:0] rateCode;
  logic [2:0] precompCode;
  logic       lowPower, swResetPulse;

  int vectors = 0, errors = 0;
  logic [1:0] mRate; logic [2:0] mPre; logic mLp; logic [7:0] mShadow; logic mPulse;

  always #4 clk = ~clk; // 125 MHz

  fdc_rate_ctrl u_fdc_rate_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] shadowOf(input logic [7:0] d);
    return {1'b0, d[6:0]};
  endfunction

  task automatic checkOutputs(input string req);
    check({req, " rate"}, rateCode, mRate);
    check({req, " precomp"}, precompCode, mPre);
    check({req, " lowPower"}, lowPower, mLp);
    check({req, " pulse"}, swResetPulse, mPulse);
  endtask

  task automatic access(input logic wr, input logic [2:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    busAddr = a; busWr = wr; busRd = !wr; busWdata = d;
    #1;
    if (!wr) check({req, " rdata"}, busRdata, (a == 3'd6) ? mShadow : 8'h00);
    mPulse = 1'b0;
    if (wr && a == 3'd4) begin
      mRate = d[1:0]; mPre = d[4:2]; mLp = d[6] & ~d[7];
      mShadow = shadowOf(d); mPulse = d[7];
    end else begin
      if (wr && a == 3'd7) mRate = d[1:0];
      if ((!wr && a == 3'd4) || a == 3'd5) mLp = 1'b0;
    end
    @(negedge clk);
    busWr = 0; busRd = 0;
    checkOutputs(req);
    if (mPulse) begin
      mPulse = 1'b0;
      @(negedge clk);
      checkOutputs({req, " pulse end"});
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    mRate = 2'b10; mPre = 0; mLp = 0; mShadow = 8'h02; mPulse = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOutputs("R1 reset");
    access(1'b0, 3'd6, 8'h00, "R1 shadow reset");
    // R2 full select write, R8 each rate code passes through
    access(1'b1, 3'd4, 8'h5f, "R2 select write");
    access(1'b0, 3'd6, 8'h00, "R2 shadow");
    for (int c = 0; c < 4; c++) access(1'b1, 3'd4, 8'(c), "R8 rate code");
    // R3 CCR write leaves precomp/power/shadow
    access(1'b1, 3'd4, 8'h54, "R3 setup");
    access(1'b1, 3'd7, 8'hff, "R3 ccr write");
    access(1'b0, 3'd6, 8'h00, "R3 shadow kept");
    // R4 last writer wins
    access(1'b1, 3'd4, 8'h01, "R4 select");
    access(1'b1, 3'd7, 8'h02, "R4 ccr after select");
    access(1'b1, 3'd4, 8'h03, "R4 select after ccr");
    // R5 self-clearing reset, clears low power
    access(1'b1, 3'd4, 8'h40, "R5 lp on");
    access(1'b1, 3'd4, 8'hcd, "R5 reset with lp bit");
    access(1'b0, 3'd6, 8'h00, "R5 shadow bit7 clear");
    // R6 exits
    access(1'b1, 3'd4, 8'h40, "R6 lp on");
    access(1'b0, 3'd4, 8'h00, "R6 status read exit");
    access(1'b1, 3'd4, 8'h40, "R6 lp on");
    access(1'b1, 3'd5, 8'h33, "R6 data write exit");
    access(1'b1, 3'd4, 8'h40, "R6 lp on");
    access(1'b0, 3'd6, 8'h00, "R6 shadow read keeps lp");
    access(1'b0, 3'd5, 8'h00, "R6 data read exit");
    // R7 select register not readable at offset 4, other offsets read 0
    access(1'b1, 3'd4, 8'h1e, "R7 setup");
    access(1'b0, 3'd4, 8'h00, "R7 offset4 read");
    access(1'b0, 3'd0, 8'h00, "R7 offset0 read");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      a = 3'($urandom_range(7, 3));
      if (a == 3'd3) a = 3'($urandom_range(2, 0));
      access(1'($urandom_range(1, 0)), a, 8'($urandom), "R4 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule